// File: doc/BRIEF.md
# Overhead Drop Serial Channel

This block takes the overhead bytes of each received frame and sends them out on a slow serial link. The bytes arrive one at a time, each tagged with its position in the 81-byte overhead block (nine rows of nine bytes, position = row * 9 + column). The block stores them in one half of a two-frame buffer. A frame marker pulse, given after the last overhead byte of a frame, swaps the halves. It then starts to send the completed frame on a serial clock, a serial data line and a sync pulse that marks the first bit. One such frame goes out every 125 µs.

A mode input picks what is sent, and the bit rate follows from it. Full mode sends all 81 bytes, which is 5.184 Mbit/s at one frame per 125 µs. The section channel mode sends only the three section data channel bytes, at 192 kbit/s. The line channel mode sends only the nine line data channel bytes, at 576 kbit/s. The serial clock comes from a clock-enable divider on the system clock. In full mode one bit lasts `DIV_FULL` system clocks, nine times that in line channel mode, and 27 times that in section channel mode. The three modes therefore take the same time per frame. A parity bit over every bit sent is shown on a status output once the frame ends. The parity sense, even or odd, is set by a configuration bit.

Top module: `ohd_serial_drop`

## Requirements
- R1: While reset is asserted and after its release, `tx_clk`, `tx_data`, `tx_sync` and `tx_parity` are low until the first `frame_mark`.
- R2: With `mode_sel` 00, or the reserved value 11, a frame sends the bytes at positions 0 to 80 in ascending order, most significant bit first. Each bit lasts `DIV_FULL` system clocks. The first bit appears in the cycle after the clock edge that samples `frame_mark`.
- R3: With `mode_sel` 01, a frame sends only the bytes at positions 18, 21 and 24, in that order, most significant bit first. Each bit lasts 27 * `DIV_FULL` system clocks.
- R4: With `mode_sel` 10, a frame sends only the bytes at positions 45 + 3k for k = 0 to 8, in that order, most significant bit first. Each bit lasts 9 * `DIV_FULL` system clocks.
- R5: `tx_sync` is high for exactly the first bit period of each frame and low at all other times.
- R6: Within each bit period of D system clocks, `tx_clk` is low for the first D/2 cycles and high for the rest. Data therefore changes on the falling edge and is stable at the rising edge.
- R7: On the clock edge that ends the last bit of a frame, `tx_parity` takes the XOR of every bit sent in that frame, inverted when odd parity was selected. It then holds that value until the end of the next frame.
- R8: The bytes sent after a `frame_mark` are the ones written at or before that edge. Writes made while a frame is being sent go to the other buffer half and do not change the bits on `tx_data`.
- R9: `mode_sel` and `odd_sel` are sampled at `frame_mark`. Changing them during a frame changes neither the rate, the bytes sent nor the parity sense of that frame.
- R10: After the last bit of a frame, `tx_clk`, `tx_data` and `tx_sync` stay low until the next `frame_mark`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovh_valid | input | 1 | An overhead byte is present on `ovh_byte` |
| ovh_pos | input | 7 | Position of the byte in the overhead block (row * 9 + column, 0 to 80) |
| ovh_byte | input | 8 | Overhead byte value |
| frame_mark | input | 1 | One-cycle pulse: the frame is complete; swap buffers and start sending |
| mode_sel | input | 2 | 00 full, 01 section channel bytes, 10 line channel bytes, 11 as full |
| odd_sel | input | 1 | 1 selects odd parity, 0 even |
| tx_clk | output | 1 | Serial clock |
| tx_data | output | 1 | Serial data, most significant bit first |
| tx_sync | output | 1 | Frame sync, high during the first bit of each frame |
| tx_parity | output | 1 | Parity over the last frame sent |

## Verification
The bench sends each mode with its own byte pattern and reads the bits back at their bit boundaries. A wrong position map or bit order would show up as mismatched bytes. A divider with the wrong ratio would smear bits or cut the frame short. One bench run writes a new frame into the buffer while the current frame is still going out. A single-buffered design would then send a mix of the two frames. A second run flips the mode and the parity sense in the middle of a frame. A design that does not sample them at the frame start would change rate or invert `tx_parity`. The bench also checks that parity stays unchanged while the link is idle, that sync lasts exactly one bit period, and that the clock phase within each bit is correct. This catches an off-by-one in the sync window or a clock that runs one phase late.

// File: rtl/ohd_pkg.sv
package ohd_pkg;

  localparam int OH_BYTES   = 81;
  localparam int OH_IDX_W   = 7;
  localparam int SEC_BASE   = 18;
  localparam int LINE_BASE  = 45;
  localparam int DCC_STRIDE = 3;
  localparam int SEC_SLOTS  = 3;
  localparam int LINE_SLOTS = 9;
  localparam int SEC_MULT   = 27;
  localparam int LINE_MULT  = 9;

  typedef enum logic [1:0] {
    OHD_FULL = 2'b00,
    OHD_SEC  = 2'b01,
    OHD_LINE = 2'b10,
    OHD_RSVD = 2'b11
  } ohd_mode_e;

  function automatic logic [OH_IDX_W-1:0] slot_last(ohd_mode_e m);
    case (m)
      OHD_SEC:  return OH_IDX_W'(SEC_SLOTS - 1);
      OHD_LINE: return OH_IDX_W'(LINE_SLOTS - 1);
      default:  return OH_IDX_W'(OH_BYTES - 1);
    endcase
  endfunction

  function automatic logic [OH_IDX_W-1:0] slot_addr(ohd_mode_e m, logic [OH_IDX_W-1:0] s);
    case (m)
      OHD_SEC:  return OH_IDX_W'(SEC_BASE)  + OH_IDX_W'(DCC_STRIDE) * s;
      OHD_LINE: return OH_IDX_W'(LINE_BASE) + OH_IDX_W'(DCC_STRIDE) * s;
      default:  return s;
    endcase
  endfunction

endpackage

// File: rtl/ohd_buffer.sv
module ohd_buffer
  import ohd_pkg::*;
#(
  parameter int N_BYTES = OH_BYTES,
  parameter int IDX_W   = OH_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             swap,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [2][N_BYTES];
  logic       wr_bank_q;
  logic       wr_bank_d;

  always_comb begin
    wr_bank_d = wr_bank_q;
    if (swap) wr_bank_d = ~wr_bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_bank_q <= 1'b0;
    else        wr_bank_q <= wr_bank_d;
  end

  // storage carries no reset; a write in the swap cycle still lands in the closing frame
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < N_BYTES)) mem[wr_bank_q][wr_idx] <= wr_data;
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_idx) < N_BYTES) rd_data = mem[~wr_bank_q][rd_idx];
  end

endmodule

// File: rtl/ohd_pacer.sv
module ohd_pacer
  import ohd_pkg::*;
#(
  parameter int DIV_FULL = 2,
  parameter int SLOT_W   = OH_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ohd_mode_e         mode_i,
  output logic              busy,
  output ohd_mode_e         mode_q,
  output logic [SLOT_W-1:0] slot,
  output logic [2:0]        bit_idx,
  output logic              bit_end,
  output logic              frame_end,
  output logic              ser_clk,
  output logic              sync
);

  localparam int MAX_DIV = DIV_FULL * SEC_MULT;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic              busy_q, busy_d;
  logic [DIV_W-1:0]  div_q, div_d, div_lim, half;
  logic [2:0]        bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  ohd_mode_e         mode_d;

  always_comb begin
    case (mode_q)
      OHD_SEC:  div_lim = DIV_W'(DIV_FULL * SEC_MULT - 1);
      OHD_LINE: div_lim = DIV_W'(DIV_FULL * LINE_MULT - 1);
      default:  div_lim = DIV_W'(DIV_FULL - 1);
    endcase
    half = DIV_W'((int'(div_lim) + 1) / 2);
  end

  assign bit_end   = busy_q && (div_q == div_lim);
  assign frame_end = bit_end && (bit_q == 3'd7) && (slot_q == slot_last(mode_q));

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    mode_d = mode_q;
    if (start) begin
      busy_d = 1'b1;
      div_d  = '0;
      bit_d  = '0;
      slot_d = '0;
      mode_d = mode_i;
    end else if (busy_q) begin
      if (bit_end) begin
        div_d = '0;
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) slot_d = slot_q + SLOT_W'(1);
        if (frame_end) busy_d = 1'b0;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      slot_q <= '0;
      mode_q <= OHD_FULL;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
      mode_q <= mode_d;
    end
  end

  assign busy    = busy_q;
  assign slot    = slot_q;
  assign bit_idx = bit_q;
  assign ser_clk = busy_q && (div_q >= half);
  assign sync    = busy_q && (slot_q == '0) && (bit_q == 3'd0);

endmodule

// File: rtl/ohd_parity.sv
module ohd_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic odd_i,
  input  logic bit_end,
  input  logic frame_end,
  input  logic bit_in,
  output logic par_out
);

  logic acc_q, acc_d;
  logic odd_q, odd_d;
  logic par_q, par_d;

  always_comb begin
    acc_d = acc_q;
    odd_d = odd_q;
    par_d = par_q;
    if (frame_end) par_d = acc_q ^ bit_in ^ odd_q;
    if (start) begin
      acc_d = 1'b0;
      odd_d = odd_i;
    end else if (bit_end) begin
      acc_d = acc_q ^ bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      odd_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      odd_q <= odd_d;
      par_q <= par_d;
    end
  end

  assign par_out = par_q;

endmodule

// File: rtl/ohd_serial_drop.sv
module ohd_serial_drop
  import ohd_pkg::*;
#(
  parameter int DIV_FULL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovh_valid,
  input  logic [6:0] ovh_pos,
  input  logic [7:0] ovh_byte,
  input  logic       frame_mark,
  input  logic [1:0] mode_sel,
  input  logic       odd_sel,
  output logic       tx_clk,
  output logic       tx_data,
  output logic       tx_sync,
  output logic       tx_parity
);

  logic                busy;
  ohd_mode_e           mode_q;
  logic [OH_IDX_W-1:0] slot;
  logic [2:0]          bit_idx;
  logic                bit_end;
  logic                frame_end;
  logic [OH_IDX_W-1:0] rd_addr;
  logic [7:0]          rd_byte;
  logic                bit_val;

  ohd_buffer #(.N_BYTES(OH_BYTES), .IDX_W(OH_IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ovh_valid),
    .wr_idx  (ovh_pos),
    .wr_data (ovh_byte),
    .swap    (frame_mark),
    .rd_idx  (rd_addr),
    .rd_data (rd_byte)
  );

  ohd_pacer #(.DIV_FULL(DIV_FULL), .SLOT_W(OH_IDX_W)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_mark),
    .mode_i    (ohd_mode_e'(mode_sel)),
    .busy      (busy),
    .mode_q    (mode_q),
    .slot      (slot),
    .bit_idx   (bit_idx),
    .bit_end   (bit_end),
    .frame_end (frame_end),
    .ser_clk   (tx_clk),
    .sync      (tx_sync)
  );

  assign rd_addr = slot_addr(mode_q, slot);
  assign bit_val = busy && rd_byte[3'd7 - bit_idx];
  assign tx_data = bit_val;

  ohd_parity u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_mark),
    .odd_i     (odd_sel),
    .bit_end   (bit_end),
    .frame_end (frame_end),
    .bit_in    (bit_val),
    .par_out   (tx_parity)
  );

endmodule

// File: rtl/ohd_checker.sv
module ohd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       bit_end,
  input logic       frame_end,
  input logic [1:0] mode_q,
  input logic       tx_clk,
  input logic       tx_data,
  input logic       tx_sync,
  input logic       tx_parity
);

  // R2: data holds for the whole bit period
  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(bit_end) && !$past(start) |-> $stable(tx_data));

  // R5: sync only begins right after a frame start
  assert_sync_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sync) |-> $past(start));

  // R7: parity changes only at the end of a frame
  assert_parity_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_parity) |-> $past(frame_end));

  // R9: the latched mode holds during a frame
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$past(start) |-> $stable(mode_q));

  // R10: quiet line when idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_clk && !tx_data && !tx_sync));

endmodule

bind ohd_serial_drop ohd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (frame_mark),
  .busy      (busy),
  .bit_end   (bit_end),
  .frame_end (frame_end),
  .mode_q    (mode_q),
  .tx_clk    (tx_clk),
  .tx_data   (tx_data),
  .tx_sync   (tx_sync),
  .tx_parity (tx_parity)
);

// File: tb/ohd_serial_drop_test.sv
module ohd_serial_drop_test;

  localparam int DIV_FULL = 2;

  logic       clk;
  logic       rst_n;
  logic       ovh_valid;
  logic [6:0] ovh_pos;
  logic [7:0] ovh_byte;
  logic       frame_mark;
  logic [1:0] mode_sel;
  logic       odd_sel;
  logic       tx_clk, tx_data, tx_sync, tx_parity;

  int checks = 0;
  int errors = 0;

  ohd_serial_drop #(.DIV_FULL(DIV_FULL)) uut (
    .clk(clk), .rst_n(rst_n), .ovh_valid(ovh_valid), .ovh_pos(ovh_pos),
    .ovh_byte(ovh_byte), .frame_mark(frame_mark), .mode_sel(mode_sel),
    .odd_sel(odd_sel), .tx_clk(tx_clk), .tx_data(tx_data),
    .tx_sync(tx_sync), .tx_parity(tx_parity)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int idx);
    return 8'((idx * 29 + seed * 71 + 5) ^ (idx << 3));
  endfunction

  function automatic int addr_of(input logic [1:0] m, input int s);
    if (m == 2'b01) return 18 + 3 * s;
    if (m == 2'b10) return 45 + 3 * s;
    return s;
  endfunction

  task automatic write_frame(input int seed);
    for (int i = 0; i < 81; i++) begin
      @(negedge clk);
      ovh_valid = 1'b1;
      ovh_pos   = 7'(i);
      ovh_byte  = exp_byte(seed, i);
    end
    @(negedge clk);
    ovh_valid = 1'b0;
  endtask

  task automatic tx_frame(input logic [1:0] m, input bit odd, input int seed, input string req);
    int div, n, data_err, clk_err, sync_err, bad_bytes, first_bad;
    logic [7:0] got [81];
    logic [7:0] exp;
    bit par;
    div = DIV_FULL * ((m == 2'b01) ? 27 : (m == 2'b10) ? 9 : 1);
    n   = (m == 2'b01) ? 3 : (m == 2'b10) ? 9 : 81;
    data_err = 0; clk_err = 0; sync_err = 0; bad_bytes = 0; first_bad = -1;
    @(negedge clk);
    mode_sel = m;
    odd_sel = odd;
    frame_mark = 1'b1;
    @(negedge clk);
    frame_mark = 1'b0;
    for (int c = 0; c < n * 8 * div; c++) begin
      int b, p;
      b = c / div;
      p = c % div;
      if (p == 0) got[b / 8][7 - (b % 8)] = tx_data;
      else if (tx_data !== got[b / 8][7 - (b % 8)]) data_err++;
      if (tx_clk !== (p >= div / 2)) clk_err++;
      if (tx_sync !== (b == 0)) sync_err++;
      @(negedge clk);
    end
    par = odd;
    for (int s = 0; s < n; s++) begin
      exp = exp_byte(seed, addr_of(m, s));
      par ^= ^exp;
      if (got[s] !== exp) begin
        bad_bytes++;
        if (first_bad < 0) first_bad = s;
      end
    end
    chk(bad_bytes == 0, req, "bytes sent (first bad slot value)",
        (first_bad < 0) ? 0 : int'(got[first_bad]),
        (first_bad < 0) ? 0 : int'(exp_byte(seed, addr_of(m, first_bad))));
    chk(data_err == 0, req, "data stable within bit (glitches)", data_err, 0);
    chk(clk_err == 0, "R6", "tx_clk phase errors", clk_err, 0);
    chk(sync_err == 0, "R5", "tx_sync window errors", sync_err, 0);
    chk(tx_parity === par, "R7", "parity after last bit", int'(tx_parity), int'(par));
    chk({tx_clk, tx_data, tx_sync} === 3'b000, "R10", "idle after frame", int'({tx_clk, tx_data, tx_sync}), 0);
  endtask

  task automatic test_reset();
    chk({tx_clk, tx_data, tx_sync, tx_parity} === 4'b0000, "R1", "outputs after reset",
        int'({tx_clk, tx_data, tx_sync, tx_parity}), 0);
  endtask

  task automatic test_full();
    write_frame(1);
    tx_frame(2'b00, 1'b0, 1, "R2");
    write_frame(2);
    tx_frame(2'b11, 1'b1, 2, "R2");
  endtask

  task automatic test_section();
    write_frame(3);
    tx_frame(2'b01, 1'b0, 3, "R3");
  endtask

  task automatic test_line();
    write_frame(4);
    tx_frame(2'b10, 1'b1, 4, "R4");
  endtask

  task automatic test_double_buffer();
    write_frame(5);
    fork
      tx_frame(2'b00, 1'b0, 5, "R8");
      begin
        repeat (3) @(negedge clk);
        write_frame(6);
      end
    join
    tx_frame(2'b00, 1'b0, 6, "R8");
  endtask

  task automatic test_latch();
    logic p0;
    write_frame(7);
    fork
      tx_frame(2'b10, 1'b1, 7, "R9");
      begin
        repeat (20) @(negedge clk);
        mode_sel = 2'b01;
        odd_sel  = 1'b0;
      end
    join
    p0 = tx_parity;
    repeat (60) @(negedge clk);
    chk(tx_parity === p0, "R7", "parity held while idle", int'(tx_parity), int'(p0));
    chk({tx_clk, tx_data, tx_sync} === 3'b000, "R10", "still idle", int'({tx_clk, tx_data, tx_sync}), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ovh_valid = 1'b0;
    ovh_pos = '0;
    ovh_byte = '0;
    frame_mark = 1'b0;
    mode_sel = 2'b00;
    odd_sel = 1'b0;
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_full();
    test_section();
    test_line();
    test_double_buffer();
    test_latch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule